// File: doc/BRIEF.md
# Super I/O configuration unlock controller

This block is the configuration gate of a legacy I/O controller. It answers at a pair of byte-wide I/O ports: an index port at a strapped base address and a data port one address above it. Out of reset it is locked, and it accepts nothing but a four-byte key written to the index port. The last key byte depends on which of the two possible base addresses the strap selects, so two such controllers on one board cannot be opened by the same sequence.

Once open, a byte written to the index port selects a configuration register, and reads and writes of the data port reach that register. The space holds a read-only 16-bit chip identifier, a logical-device select register, a flash-decode control register, and a 16-bit I/O base address that belongs to logical device 7 only. Writing the lock code to the lock register closes the gate again. The register contents are presented as decoded outputs for the rest of the chip. The access interface is a simple synchronous write/read strobe; bus-cycle decoding is done elsewhere.

Top module: `sio_cfg_unlock`

## Requirements
- R1: After reset the block is locked (`cfg_unlocked` = 0), the selected index and the logical device are 0x00, the flash control register is 0x02 (so `seg_en` = 3'b001, `flash_wr_en` = 0, `flash_pin_alt` = 0), `dev_base` is 0x0820 and `io_rdata` is 0xFF.
- R2: With `strap_alt` = 0 the index port is 0x2E and the key 0x87, 0x01, 0x55, 0x55 written there unlocks the block; with `strap_alt` = 1 the index port is 0x4E and the last key byte is 0xAA instead. The other base's fourth byte does not unlock. `cfg_unlocked` is 1 from the clock edge that takes the fourth byte.
- R3: A byte at the index port that does not match the expected key byte sends the matcher back to its first stage, and that byte is not itself counted as a first key byte, even when it is 0x87.
- R4: While locked, every read of the index or data port returns 0xFF and data-port writes change no register.
- R5: While unlocked, a write to the index port (base) selects the register, a read of the index port returns the selected index, and the data port (base+1) reads and writes the selected register.
- R6: Registers 0x20 and 0x21 read the chip identifier high and low bytes (default 0x8716) and ignore writes.
- R7: Writing 0x02 to register 0x02 locks the block; any other value written there has no effect; register 0x02 reads 0x00.
- R8: Register 0x07 selects the logical device (read/write, output `ldn_sel`). Registers 0x64 (high byte) and 0x65 (low byte) reach `dev_base` only while the selected device is 7; otherwise they read 0x00 and ignore writes.
- R9: In register 0x24, bits 5:1 are read/write and bits 0, 6 and 7 read 0 and ignore writes; bit 0 is the suspend flag that stays clear. Bits 3:1 drive `seg_en[2:0]`, bit 4 drives `flash_wr_en` and bit 5 drives `flash_pin_alt`.
- R10: Unmapped register indices read 0x00; reads of any I/O address other than the base and base+1 return 0xFF, and writes to such addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Base select: 0 for 0x2E, 1 for 0x4E |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered, held between reads |
| cfg_unlocked | output | 1 | Configuration space is open |
| ldn_sel | output | 8 | Selected logical device |
| seg_en | output | 3 | Flash decode segment enables |
| flash_wr_en | output | 1 | Host writes to the serial flash allowed |
| flash_pin_alt | output | 1 | Alternate flash chip-select pin selected |
| dev_base | output | 16 | I/O base address of logical device 7 |

## Verification
Every write takes effect at the clock edge on which its strobe is high, so the key state, the lock flag and all decoded outputs are due one edge after the write; the bench drives strobes on the falling edge and observes the next falling edge. Read data is captured at the edge that sees `io_rd` and held, so each read result is sampled half a cycle after that edge, before another read can change it. Ignored writes are checked by reading the register back, or the output it drives, after the write and before any other access changes it.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int KEY_LEN = 4;

  // register indices inside the configuration space
  localparam logic [7:0] IDX_LOCK    = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_FLASH   = 8'h24;
  localparam logic [7:0] IDX_BASE_HI = 8'h64;
  localparam logic [7:0] IDX_BASE_LO = 8'h65;

  localparam logic [7:0] LOCK_CODE     = 8'h02;
  localparam logic [7:0] DEV_WITH_BASE = 8'h07;
  localparam logic [7:0] FLASH_WR_MASK = 8'h3E;
  localparam logic [7:0] IDLE_READ     = 8'hFF;

  // expected key byte for a given stage; the last one depends on the strap
  function automatic logic [7:0] key_byte(input int stage, input logic alt);
    case (stage)
      0:       key_byte = 8'h87;
      1:       key_byte = 8'h01;
      2:       key_byte = 8'h55;
      default: key_byte = alt ? 8'hAA : 8'h55;
    endcase
  endfunction

  // merge a data-port write into the flash control register
  function automatic logic [7:0] flash_ctl_next(input logic [7:0] wdata);
    flash_ctl_next = wdata & FLASH_WR_MASK;
  endfunction

  function automatic logic [2:0] seg_field(input logic [7:0] ctl);
    seg_field = ctl[3:1];
  endfunction

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] BASE_PRI = 16'h002E,
  parameter logic [15:0] BASE_ALT = 16'h004E
) (
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              dat_wr,
  output logic              dat_rd
);

  logic [ADDR_W-1:0] base_idx;
  logic [ADDR_W-1:0] base_dat;
  logic              hit_idx;
  logic              hit_dat;

  always_comb begin
    base_idx = strap_alt ? BASE_ALT[ADDR_W-1:0] : BASE_PRI[ADDR_W-1:0];
    base_dat = base_idx + {{(ADDR_W-1){1'b0}}, 1'b1};
    hit_idx  = (io_addr == base_idx);
    hit_dat  = (io_addr == base_dat);
    idx_wr   = io_wr & hit_idx;
    idx_rd   = io_rd & hit_idx;
    dat_wr   = io_wr & hit_dat;
    dat_rd   = io_rd & hit_dat;
  end

endmodule

// File: rtl/sio_key_match.sv
module sio_key_match
  import sio_cfg_pkg::*;
#(
  parameter int N_KEY = KEY_LEN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_alt,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  input  logic       lock_req,
  output logic       unlocked
);

  localparam int STAGE_W = (N_KEY > 1) ? $clog2(N_KEY) : 1;
  localparam logic [STAGE_W-1:0] LAST_STAGE = STAGE_W'(N_KEY - 1);

  logic [STAGE_W-1:0] stage_q;
  logic               unl_q;
  logic               byte_ok;
  logic               key_step;
  logic               key_miss;
  logic               key_done;

  always_comb begin
    byte_ok  = (wdata == key_byte(int'(stage_q), strap_alt));
    key_step = idx_wr & ~unl_q & byte_ok;
    key_miss = idx_wr & ~unl_q & ~byte_ok;
    key_done = key_step & (stage_q == LAST_STAGE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      unl_q   <= 1'b0;
    end else if (lock_req) begin
      stage_q <= '0;
      unl_q   <= 1'b0;
    end else if (key_done) begin
      stage_q <= '0;
      unl_q   <= 1'b1;
    end else if (key_step) begin
      stage_q <= stage_q + 1'b1;
    end else if (key_miss) begin
      stage_q <= '0;
    end
  end

  assign unlocked = unl_q;

  // R2: the gate only opens on an index-port write
  a_r2_open_on_index_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl_q) |-> $past(idx_wr));

  // R3: a wrong byte leaves the matcher at its first stage and locked
  a_r3_miss_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (key_miss && !lock_req) |=> (stage_q == '0) && !unl_q);

  // R7: a lock request always closes the gate
  a_r7_lock_closes: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req |=> !unl_q);

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID   = 16'h8716,
  parameter logic [7:0]  FLASH_RST = 8'h02,
  parameter logic [15:0] BASE_RST  = 16'h0820
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        unlocked,
  input  logic        idx_wr,
  input  logic        dat_wr,
  input  logic [7:0]  wdata,
  output logic [7:0]  index,
  output logic [7:0]  ldn,
  output logic [7:0]  flash_ctl,
  output logic [15:0] dev_base,
  output logic        lock_req,
  output logic [7:0]  rd_value
);

  logic [7:0]  index_q;
  logic [7:0]  ldn_q;
  logic [7:0]  flash_q;
  logic [15:0] base_q;
  logic        bank_on;
  logic        cfg_wr;

  always_comb begin
    bank_on  = (ldn_q == DEV_WITH_BASE);
    cfg_wr   = dat_wr & unlocked;
    lock_req = cfg_wr & (index_q == IDX_LOCK) & (wdata == LOCK_CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= 8'h00;
    end else if (idx_wr && unlocked) begin
      index_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldn_q   <= 8'h00;
      flash_q <= FLASH_RST & FLASH_WR_MASK;
      base_q  <= BASE_RST;
    end else if (cfg_wr) begin
      case (index_q)
        IDX_LDN:     ldn_q   <= wdata;
        IDX_FLASH:   flash_q <= flash_ctl_next(wdata);
        IDX_BASE_HI: if (bank_on) base_q[15:8] <= wdata;
        IDX_BASE_LO: if (bank_on) base_q[7:0]  <= wdata;
        default:     ;
      endcase
    end
  end

  always_comb begin
    case (index_q)
      IDX_LDN:     rd_value = ldn_q;
      IDX_ID_HI:   rd_value = CHIP_ID[15:8];
      IDX_ID_LO:   rd_value = CHIP_ID[7:0];
      IDX_FLASH:   rd_value = flash_q;
      IDX_BASE_HI: rd_value = bank_on ? base_q[15:8] : 8'h00;
      IDX_BASE_LO: rd_value = bank_on ? base_q[7:0]  : 8'h00;
      default:     rd_value = 8'h00;
    endcase
  end

  assign index     = index_q;
  assign ldn       = ldn_q;
  assign flash_ctl = flash_q;
  assign dev_base  = base_q;

  // R4: data-port writes while locked change no register
  a_r4_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !unlocked) |=> $stable(ldn_q) && $stable(flash_q) && $stable(base_q));

  // R8: the base pair is frozen unless device 7 is selected
  a_r8_base_banked: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && (ldn_q != DEV_WITH_BASE)) |=> $stable(base_q));

  // R9: the suspend flag never becomes set
  a_r9_suspend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> !flash_q[0]);

  // R5: the index only moves on an unlocked index-port write
  a_r5_index_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_wr && unlocked) |=> $stable(index_q));

endmodule

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_PRI  = 16'h002E,
  parameter logic [15:0] BASE_ALT  = 16'h004E,
  parameter logic [15:0] CHIP_ID   = 16'h8716,
  parameter logic [7:0]  FLASH_RST = 8'h02,
  parameter logic [15:0] BASE_RST  = 16'h0820
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cfg_unlocked,
  output logic [7:0]        ldn_sel,
  output logic [2:0]        seg_en,
  output logic              flash_wr_en,
  output logic              flash_pin_alt,
  output logic [15:0]       dev_base
);

  logic       idx_wr, idx_rd, dat_wr, dat_rd;
  logic       unlocked;
  logic       lock_req;
  logic [7:0] index;
  logic [7:0] flash_ctl;
  logic [7:0] rd_value;
  logic [7:0] rd_next;

  sio_port_decode #(
    .ADDR_W   (ADDR_W),
    .BASE_PRI (BASE_PRI),
    .BASE_ALT (BASE_ALT)
  ) u_decode (
    .strap_alt (strap_alt),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .idx_wr    (idx_wr),
    .idx_rd    (idx_rd),
    .dat_wr    (dat_wr),
    .dat_rd    (dat_rd)
  );

  sio_key_match #(
    .N_KEY (KEY_LEN)
  ) u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_alt (strap_alt),
    .idx_wr    (idx_wr),
    .wdata     (io_wdata),
    .lock_req  (lock_req),
    .unlocked  (unlocked)
  );

  sio_cfg_regs #(
    .CHIP_ID   (CHIP_ID),
    .FLASH_RST (FLASH_RST),
    .BASE_RST  (BASE_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .unlocked  (unlocked),
    .idx_wr    (idx_wr),
    .dat_wr    (dat_wr),
    .wdata     (io_wdata),
    .index     (index),
    .ldn       (ldn_sel),
    .flash_ctl (flash_ctl),
    .dev_base  (dev_base),
    .lock_req  (lock_req),
    .rd_value  (rd_value)
  );

  always_comb begin
    if (!unlocked)   rd_next = IDLE_READ;
    else if (idx_rd) rd_next = index;
    else if (dat_rd) rd_next = rd_value;
    else             rd_next = IDLE_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     io_rdata <= IDLE_READ;
    else if (io_rd) io_rdata <= rd_next;
  end

  assign cfg_unlocked  = unlocked;
  assign seg_en        = seg_field(flash_ctl);
  assign flash_wr_en   = flash_ctl[4];
  assign flash_pin_alt = flash_ctl[5];

  // R4: locked data-port reads return all ones
  a_r4_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !unlocked) |=> (io_rdata == 8'hFF));

  // R10: reads outside the two ports return all ones
  a_r10_foreign_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !idx_rd && !dat_rd) |=> (io_rdata == 8'hFF));

endmodule

// File: tb/test_sio_cfg_unlock.sv
module test_sio_cfg_unlock;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_alt = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        cfg_unlocked;
  logic [7:0]  ldn_sel;
  logic [2:0]  seg_en;
  logic        flash_wr_en;
  logic        flash_pin_alt;
  logic [15:0] dev_base;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_unlock i_sio_cfg_unlock (
    .clk           (clk),
    .rst_n         (rst_n),
    .strap_alt     (strap_alt),
    .io_addr       (io_addr),
    .io_wr         (io_wr),
    .io_rd         (io_rd),
    .io_wdata      (io_wdata),
    .io_rdata      (io_rdata),
    .cfg_unlocked  (cfg_unlocked),
    .ldn_sel       (ldn_sel),
    .seg_en        (seg_en),
    .flash_wr_en   (flash_wr_en),
    .flash_pin_alt (flash_pin_alt),
    .dev_base      (dev_base)
  );

  // vector: {read, address, data or expected, requirement number}
  localparam int NV = 62;
  localparam logic [32:0] VECS [NV] = '{
    {1'b1, 16'h002F, 8'hFF, 8'd4},  // R4 locked data read
    {1'b0, 16'h002F, 8'h3E, 8'd4},  // R4 locked write, checked later via 0x24
    {1'b1, 16'h002E, 8'hFF, 8'd4},  // R4 locked index read
    {1'b0, 16'h002E, 8'h87, 8'd3},  // R3 good first byte
    {1'b0, 16'h002E, 8'h01, 8'd3},
    {1'b0, 16'h002E, 8'h77, 8'd3},  // R3 wrong byte
    {1'b0, 16'h002E, 8'h01, 8'd3},
    {1'b0, 16'h002E, 8'h55, 8'd3},
    {1'b0, 16'h002E, 8'h55, 8'd3},
    {1'b1, 16'h002F, 8'hFF, 8'd3},  // R3 still locked
    {1'b0, 16'h002E, 8'h87, 8'd3},
    {1'b0, 16'h002E, 8'h87, 8'd3},  // R3 repeated 0x87 is a miss, not a restart
    {1'b0, 16'h002E, 8'h01, 8'd3},
    {1'b0, 16'h002E, 8'h55, 8'd3},
    {1'b0, 16'h002E, 8'h55, 8'd3},
    {1'b1, 16'h002F, 8'hFF, 8'd3},  // R3 still locked
    {1'b0, 16'h002E, 8'h87, 8'd2},
    {1'b0, 16'h002E, 8'h01, 8'd2},
    {1'b0, 16'h002E, 8'h55, 8'd2},
    {1'b0, 16'h002E, 8'hAA, 8'd2},  // R2 other base's fourth byte
    {1'b1, 16'h002F, 8'hFF, 8'd2},
    {1'b0, 16'h002E, 8'h87, 8'd2},
    {1'b0, 16'h002E, 8'h01, 8'd2},
    {1'b0, 16'h002E, 8'h55, 8'd2},
    {1'b0, 16'h002E, 8'h55, 8'd2},  // R2 unlocks
    {1'b1, 16'h002E, 8'h00, 8'd5},  // R5 index readback, reset index
    {1'b0, 16'h002E, 8'h20, 8'd6},
    {1'b1, 16'h002F, 8'h87, 8'd6},  // R6 id high
    {1'b0, 16'h002E, 8'h21, 8'd6},
    {1'b1, 16'h002F, 8'h16, 8'd6},  // R6 id low
    {1'b0, 16'h002F, 8'h00, 8'd6},
    {1'b1, 16'h002F, 8'h16, 8'd6},  // R6 read-only
    {1'b1, 16'h002E, 8'h21, 8'd5},  // R5 index readback
    {1'b0, 16'h002E, 8'h24, 8'd9},
    {1'b1, 16'h002F, 8'h02, 8'd4},  // R4 locked write left reset value
    {1'b0, 16'h002F, 8'hFF, 8'd9},
    {1'b1, 16'h002F, 8'h3E, 8'd9},  // R9 reserved bits stay 0
    {1'b0, 16'h002E, 8'h64, 8'd8},
    {1'b1, 16'h002F, 8'h00, 8'd8},  // R8 bank off reads 0
    {1'b0, 16'h002F, 8'h12, 8'd8},  // R8 write ignored
    {1'b0, 16'h002E, 8'h07, 8'd8},
    {1'b0, 16'h002F, 8'h07, 8'd8},
    {1'b1, 16'h002F, 8'h07, 8'd8},  // R8 ldn readback
    {1'b0, 16'h002E, 8'h64, 8'd8},
    {1'b1, 16'h002F, 8'h08, 8'd8},  // R8 reset base high, earlier write dropped
    {1'b0, 16'h002F, 8'hAB, 8'd8},
    {1'b0, 16'h002E, 8'h65, 8'd8},
    {1'b1, 16'h002F, 8'h20, 8'd8},  // R8 reset base low
    {1'b0, 16'h002F, 8'hCD, 8'd8},
    {1'b1, 16'h002F, 8'hCD, 8'd8},
    {1'b0, 16'h002E, 8'h64, 8'd8},
    {1'b1, 16'h002F, 8'hAB, 8'd8},
    {1'b0, 16'h002E, 8'h30, 8'd10},
    {1'b1, 16'h002F, 8'h00, 8'd10}, // R10 unmapped index
    {1'b1, 16'h0080, 8'hFF, 8'd10}, // R10 foreign address
    {1'b0, 16'h004F, 8'h02, 8'd10}, // R10 other base ignored
    {1'b0, 16'h002E, 8'h02, 8'd7},
    {1'b0, 16'h002F, 8'h05, 8'd7},  // R7 wrong code
    {1'b1, 16'h002F, 8'h00, 8'd7},  // R7 reads 0, still unlocked
    {1'b0, 16'h002F, 8'h02, 8'd7},  // R7 lock
    {1'b1, 16'h002F, 8'hFF, 8'd7},
    {1'b1, 16'h002E, 8'hFF, 8'd7}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic do_reset(input logic alt);
    @(negedge clk);
    rst_n = 1'b0; strap_alt = alt;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_key(input logic [15:0] a, input logic [7:0] last);
    io_write(a, 8'h87); io_write(a, 8'h01); io_write(a, 8'h55); io_write(a, last);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 unlocked", cfg_unlocked, 0);
    check("R1 ldn", ldn_sel, 8'h00);
    check("R1 seg_en", seg_en, 3'b001);
    check("R1 wr_en", flash_wr_en, 0);
    check("R1 pin_alt", flash_pin_alt, 0);
    check("R1 dev_base", dev_base, 16'h0820);
    check("R1 rdata", io_rdata, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec %0d", v[7:0], i);
      if (v[32]) begin
        io_read(v[31:16], rd);
        check(tag, rd, v[15:8]);
      end else begin
        io_write(v[31:16], v[15:8]);
      end
    end

    // outputs after the walk (gate closed, registers kept)
    check("R7 locked", cfg_unlocked, 0);
    check("R9 seg_en", seg_en, 3'b111);
    check("R9 wr_en", flash_wr_en, 1);
    check("R9 pin_alt", flash_pin_alt, 1);
    check("R8 dev_base", dev_base, 16'hABCD);
    check("R8 ldn_sel", ldn_sel, 8'h07);

    // R9 decode with a sparse pattern
    send_key(16'h002E, 8'h55);
    check("R2 unlocked", cfg_unlocked, 1);
    io_write(16'h002E, 8'h24);
    io_write(16'h002F, 8'h15);
    check("R9 seg_en 0x14", seg_en, 3'b010);
    check("R9 wr_en 0x14", flash_wr_en, 1);
    check("R9 pin_alt 0x14", flash_pin_alt, 0);
    io_read(16'h002F, rd);
    check("R9 read 0x14", rd, 8'h14);

    // R2 alternate base
    do_reset(1'b1);
    send_key(16'h004E, 8'h55);
    check("R2 alt wrong last byte", cfg_unlocked, 0);
    send_key(16'h002E, 8'hAA);
    check("R2 alt key at primary base", cfg_unlocked, 0);
    send_key(16'h004E, 8'hAA);
    check("R2 alt unlocked", cfg_unlocked, 1);
    io_write(16'h004E, 8'h20);
    io_read(16'h004F, rd);
    check("R5 alt data port", rd, 8'h87);
    io_read(16'h002F, rd);
    check("R10 primary port under alt strap", rd, 8'hFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule